// File: doc/BRIEF.md
# I2C Synthesizer Control Slave

This block is the serial control front end of a frequency synthesizer. It listens on an I2C bus (standard or fast mode) through a system clock. It answers one of four device addresses, picked by a two-bit select input. It holds every programmable field of the synthesizer: the 15-bit loop division ratio, the reference divider code, the charge-pump current code, band and IF selection, four general purpose port drives and the test-mode bits. A read returns a status byte. That byte carries a power-on flag, the loop-lock flag and the two address-select bits.

Data bytes arrive in pairs and carry no register address. The first bit of the first byte of each pair says whether the pair holds the division ratio or the control fields. Pairs may follow one another until a STOP arrives. The division ratio reaches the divider in one step, once both of its bytes are in or a STOP ends the transfer. When the test-enable bit is set, three of the port bits become a test selector. The selector forces the charge-pump mode and the reported lock flag, and it can route a divider or comparison clock to port 0.

The bus engine is a state machine with these states: `S_IDLE`, `S_ADDR` (address bits), `S_ADDR_ACK`, `S_WR_BYTE`, `S_WR_ACK`, `S_RD_BYTE` and `S_RD_ACK`. Its transitions are:
- From any state, a START goes to `S_ADDR` and a STOP goes to `S_IDLE`.
- `S_ADDR` moves on after the eighth bit: to `S_ADDR_ACK` when the address matches, otherwise back to `S_IDLE`.
- `S_ADDR_ACK` goes to `S_WR_BYTE` or `S_RD_BYTE`, according to the read/write bit.
- `S_WR_BYTE` goes to `S_WR_ACK` after eight bits, and `S_WR_ACK` returns to `S_WR_BYTE`.
- `S_RD_BYTE` goes to `S_RD_ACK` after eight bits.
- From `S_RD_ACK`, a master acknowledge goes back to `S_RD_BYTE`. A missing master acknowledge goes to `S_IDLE`, which acts as an internal stop.

A separate pair-phase register (`PH_FIRST`, `PH_FREQ_LO`, `PH_CTRL_B`) tracks where the block is within a byte pair.

Top module: `synth_ctl_i2c`

## Requirements
- R1: The block acknowledges only an address byte equal to 1,1,0,0,0,addr_sel[1],addr_sel[0],rw (MSB first; rw 0 = write, 1 = read). For any other address byte it never pulls SDA low, and the data bytes that follow change no field.
- R2: A first-of-pair data byte with bit 7 = 0 carries ratio bits 14..8 in its bits 6..0. The next byte carries ratio bits 7..0. `div_ratio` keeps its old value until that second byte is complete, then takes all 15 bits at once.
- R3: When a STOP follows a lone ratio high byte, `div_ratio` takes the new bits 14..8 and keeps its previous bits 7..0.
- R4: A first-of-pair byte with bit 7 = 1 sets `cp_code` from bits 6..5 and `ref_code` from bits 4..0. The next byte sets `if_sel` from bit 7, `band_code` from bits 6..5, `test_en` from bit 4 and the port/test bits from bits 3..0. Every code, including cp 11 and band 10 and 11, is stored as written.
- R5: Byte pairs may follow one another in one write transfer without a new address. The first bit of each pair decides its type.
- R6: A STOP inside a data byte throws away the partial byte. All fields written by earlier complete bytes keep their values.
- R7: The block pulls SDA low during the ninth clock after a matching address and after every data byte written to it.
- R8: A read returns the status byte {POR, FL, 0, 0, 0, addr_sel[1], addr_sel[0], 0}, MSB first. The byte is sent again each time the master acknowledges.
- R9: When the master does not acknowledge a status byte, the block releases SDA and ignores further clocks until the next START.
- R10: The POR flag is 1 after reset and after a `por_evt` pulse. A STOP that ends a read transfer clears it.
- R11: With `test_en` = 0, `port_drv` equals the four written port bits, `cp_mode` is 00 (normal), and the status FL bit equals `pll_lock`.
- R12: With `test_en` = 1 the test selector t = port bits 3..1 decides the outputs, and `port_drv[3:1]` = 0. `cp_mode` encodes 01 sink, 10 source, 11 off. The table is:
  - t=000: normal, P0 off.
  - t=001: normal, P0 = `fdiv_half`.
  - t=010: sink, FL=0.
  - t=011: source, FL=0.
  - t=100: off, FL=1.
  - t=101: sink, FL=0, P0 = `fcmp`.
  - t=110: source, FL=0, P0 = `fcmp`.
  - t=111: off, FL=1, P0 = `fcmp`.
  - Where FL is not forced it follows `pll_lock`; where P0 is not a clock it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_sel | input | 2 | Variable device address bits |
| por_evt | input | 1 | Power-on or low-supply event pulse |
| pll_lock | input | 1 | Lock indication from the phase detector |
| fdiv_half | input | 1 | Programmable divider output divided by two |
| fcmp | input | 1 | Comparison-frequency clock |
| sda_pull | output | 1 | 1 pulls the data line low |
| div_ratio | output | 15 | Loop division ratio |
| ref_code | output | 5 | Reference divider code |
| cp_code | output | 2 | Charge-pump current code |
| band_code | output | 2 | Oscillator band code |
| if_sel | output | 1 | Image-reject passband select |
| test_en | output | 1 | Test mode enable |
| port_drv | output | 4 | Port switch drives, 1 = on |
| cp_mode | output | 2 | Charge-pump mode: 00 normal, 01 sink, 10 source, 11 off |

## Verification
The assertions watch the SDA pull on every cycle. It must be active through each acknowledge state, must never be active while idle, and must drop at once after a missing master acknowledge. They also check that the division ratio moves only in the cycle after a completed byte or a STOP, and that a power-on event always raises the flag. The meaning of the bytes can only be shown by the bench's transfers: the pair decoding, the atomic ratio update, a partial byte lost to a STOP, a foreign address ignored, the POR clearing and the test-mode table.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 15;
    localparam int REF_W  = 5;
    localparam int PORT_N = 4;
    localparam int HI_W   = DIV_W - BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_WR_BYTE, S_WR_ACK, S_RD_BYTE, S_RD_ACK
    } bus_state_t;

    typedef enum logic [1:0] {
        PH_FIRST, PH_FREQ_LO, PH_CTRL_B
    } pair_phase_t;

    typedef enum logic [1:0] {
        CP_NORMAL = 2'b00, CP_SINK = 2'b01, CP_SOURCE = 2'b10, CP_OFF = 2'b11
    } cp_mode_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s    = scl_sh[STAGES-1];
    assign sda_s    = sda_sh[STAGES-1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/synth_test_decode.sv
module synth_test_decode
    import synth_ctl_pkg::*;
(
    input  logic              test_en,
    input  logic [PORT_N-1:0] port_bits,
    input  logic              pll_lock,
    input  logic              fdiv_half,
    input  logic              fcmp,
    output logic [PORT_N-1:0] port_drv,
    output logic [1:0]        cp_mode,
    output logic              lock_flag
);
    logic [2:0] tsel;
    assign tsel = port_bits[3:1];

    always_comb begin
        port_drv  = port_bits;
        cp_mode   = CP_NORMAL;
        lock_flag = pll_lock;
        if (test_en) begin
            port_drv = '0;
            unique case (tsel)
                3'b000: ;
                3'b001: port_drv[0] = fdiv_half;
                3'b010: begin cp_mode = CP_SINK;   lock_flag = 1'b0; end
                3'b011: begin cp_mode = CP_SOURCE; lock_flag = 1'b0; end
                3'b100: begin cp_mode = CP_OFF;    lock_flag = 1'b1; end
                3'b101: begin cp_mode = CP_SINK;   lock_flag = 1'b0; port_drv[0] = fcmp; end
                3'b110: begin cp_mode = CP_SOURCE; lock_flag = 1'b0; port_drv[0] = fcmp; end
                3'b111: begin cp_mode = CP_OFF;    lock_flag = 1'b1; port_drv[0] = fcmp; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/synth_ctl_i2c.sv
module synth_ctl_i2c
    import synth_ctl_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b11000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    input  logic              por_evt,
    input  logic              pll_lock,
    input  logic              fdiv_half,
    input  logic              fcmp,
    output logic              sda_pull,
    output logic [DIV_W-1:0]  div_ratio,
    output logic [REF_W-1:0]  ref_code,
    output logic [1:0]        cp_code,
    output logic [1:0]        band_code,
    output logic              if_sel,
    output logic              test_en,
    output logic [PORT_N-1:0] port_drv,
    output logic [1:0]        cp_mode
);
    bus_state_t        state, nxt;
    pair_phase_t       phase;
    logic              sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg, tx, status;
    logic [HI_W-1:0]   stage_hi;
    logic [PORT_N-1:0] port_bits;
    logic              por_flag, rd_txn, lock_flag, addr_hit, byte_end, byte_done;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    synth_test_decode u_tdec (
        .test_en(test_en), .port_bits(port_bits), .pll_lock(pll_lock),
        .fdiv_half(fdiv_half), .fcmp(fcmp),
        .port_drv(port_drv), .cp_mode(cp_mode), .lock_flag(lock_flag)
    );

    assign addr_hit  = (shreg[7:1] == {ADDR_PREFIX, addr_sel});
    assign byte_end  = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign byte_done = (state == S_WR_BYTE) && byte_end;
    assign status    = {por_flag, lock_flag, 3'b000, addr_sel, 1'b0};

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_p)       nxt = S_IDLE;
        else if (start_p) nxt = S_ADDR;
        else begin
            unique case (state)
                S_IDLE:     ;
                S_ADDR:     if (byte_end) nxt = addr_hit ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK: if (scl_fall) nxt = shreg[0] ? S_RD_BYTE : S_WR_BYTE;
                S_WR_BYTE:  if (byte_end) nxt = S_WR_ACK;
                S_WR_ACK:   if (scl_fall) nxt = S_WR_BYTE;
                S_RD_BYTE:  if (byte_end) nxt = S_RD_ACK;
                S_RD_ACK:   if (scl_rise && sda_s) nxt = S_IDLE;
                            else if (scl_fall)     nxt = S_RD_BYTE;
                default:    nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // shifting, line drive and field registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            tx        <= '0;
            stage_hi  <= '0;
            phase     <= PH_FIRST;
            sda_pull  <= 1'b0;
            rd_txn    <= 1'b0;
            por_flag  <= 1'b1;
            div_ratio <= '0;
            ref_code  <= '0;
            cp_code   <= '0;
            band_code <= '0;
            if_sel    <= 1'b0;
            test_en   <= 1'b0;
            port_bits <= '0;
        end else begin
            if (por_evt)                por_flag <= 1'b1;
            else if (stop_p && rd_txn)  por_flag <= 1'b0;

            if (start_p) begin
                bit_cnt <= '0;
                phase   <= PH_FIRST;
                rd_txn  <= 1'b0;
            end
            if (stop_p) begin
                rd_txn <= 1'b0;
                phase  <= PH_FIRST;
                if (phase == PH_FREQ_LO) div_ratio <= {stage_hi, div_ratio[BYTE_W-1:0]};
            end

            if (scl_rise && (state == S_ADDR || state == S_WR_BYTE)) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_rise && state == S_RD_BYTE) bit_cnt <= bit_cnt + 1'b1;

            if (byte_done) begin
                unique case (phase)
                    PH_FIRST: begin
                        if (!shreg[7]) begin
                            stage_hi <= shreg[HI_W-1:0];
                            phase    <= PH_FREQ_LO;
                        end else begin
                            cp_code  <= shreg[6:5];
                            ref_code <= shreg[REF_W-1:0];
                            phase    <= PH_CTRL_B;
                        end
                    end
                    PH_FREQ_LO: begin
                        div_ratio <= {stage_hi, shreg};
                        phase     <= PH_FIRST;
                    end
                    PH_CTRL_B: begin
                        if_sel    <= shreg[7];
                        band_code <= shreg[6:5];
                        test_en   <= shreg[4];
                        port_bits <= shreg[PORT_N-1:0];
                        phase     <= PH_FIRST;
                    end
                    default: phase <= PH_FIRST;
                endcase
            end

            if (nxt == S_IDLE) begin
                sda_pull <= 1'b0;
            end else if (!stop_p && !start_p) begin
                unique case (state)
                    S_ADDR: if (byte_end && addr_hit) begin
                        sda_pull <= 1'b1;
                        rd_txn   <= shreg[0];
                    end
                    S_ADDR_ACK, S_RD_ACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (state == S_RD_ACK || shreg[0]) begin
                            tx       <= status;
                            sda_pull <= ~status[7];
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end
                    S_WR_BYTE: if (byte_end) sda_pull <= 1'b1;
                    S_WR_ACK: if (scl_fall) begin
                        sda_pull <= 1'b0;
                        bit_cnt  <= '0;
                    end
                    S_RD_BYTE: if (scl_fall) begin
                        if (byte_end) sda_pull <= 1'b0;
                        else          sda_pull <= ~tx[3'(BYTE_W - 1) - bit_cnt[2:0]];
                    end
                    default: ;
                endcase
            end
        end
    end

    // assertions
    assert_addr_ack_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR_ACK) |-> sda_pull);
    assert_data_ack_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR_ACK) |-> sda_pull);
    assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_pull);
    assert_nack_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_ACK && scl_rise && sda_s && !stop_p && !start_p)
        |=> (state == S_IDLE && !sda_pull));
    assert_por_raised_R10: assert property (@(posedge clk) disable iff (!rst_n)
        por_evt |=> por_flag);
    assert_ratio_atomic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_ratio) |-> $past(byte_done || stop_p));
endmodule

// File: tb/synth_ctl_i2c_test.sv
module synth_ctl_i2c_test;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b10;
    logic por_evt = 1'b0, pll_lock = 1'b0, fdiv_half = 1'b0, fcmp = 1'b0;
    logic sda_pull, if_sel, test_en;
    logic [14:0] div_ratio;
    logic [4:0] ref_code;
    logic [1:0] cp_code, band_code, cp_mode;
    logic [3:0] port_drv;
    wire sda_line = sda_m & ~sda_pull;

    synth_ctl_i2c uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .por_evt(por_evt), .pll_lock(pll_lock),
        .fdiv_half(fdiv_half), .fcmp(fcmp), .sda_pull(sda_pull),
        .div_ratio(div_ratio), .ref_code(ref_code), .cp_code(cp_code),
        .band_code(band_code), .if_sel(if_sel), .test_en(test_en),
        .port_drv(port_drv), .cp_mode(cp_mode)
    );

    int n_chk = 0, n_fail = 0;
    logic [14:0] e_div = '0;
    logic [6:0]  e_hi = '0;
    logic [4:0]  e_ref = '0;
    logic [1:0]  e_cp = '0, e_band = '0, e_ph = '0;
    logic        e_if = 0, e_te = 0, e_por = 1;
    logic [3:0]  e_pb = '0;

    task automatic hq(); repeat (Q) @(negedge clk); endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] f_ports(logic te, logic [3:0] pb, logic fd, logic fc);
        logic [2:0] t = pb[3:1];
        if (!te) return pb;
        if (t == 3'b001) return {3'b000, fd};
        if (t[2] && t != 3'b100) return {3'b000, fc};
        return 4'b0000;
    endfunction

    function automatic logic [1:0] f_cp(logic te, logic [3:0] pb);
        if (!te) return 2'b00;
        case (pb[3:1])
            3'b010, 3'b101: return 2'b01;
            3'b011, 3'b110: return 2'b10;
            3'b100, 3'b111: return 2'b11;
            default:        return 2'b00;
        endcase
    endfunction

    function automatic logic f_fl(logic te, logic [3:0] pb, logic lk);
        if (!te) return lk;
        case (pb[3:1])
            3'b100, 3'b111:                 return 1'b1;
            3'b010, 3'b011, 3'b101, 3'b110: return 1'b0;
            default:                        return lk;
        endcase
    endfunction

    task automatic m_byte(input logic [7:0] b);
        case (e_ph)
            2'd0: if (!b[7]) begin e_hi = b[6:0]; e_ph = 2'd1; end
                  else begin e_cp = b[6:5]; e_ref = b[4:0]; e_ph = 2'd2; end
            2'd1: begin e_div = {e_hi, b}; e_ph = 2'd0; end
            default: begin e_if = b[7]; e_band = b[6:5]; e_te = b[4]; e_pb = b[3:0]; e_ph = 2'd0; end
        endcase
    endtask

    task automatic m_stop();
        if (e_ph == 2'd1) e_div = {e_hi, e_div[7:0]};
        e_ph = 2'd0;
    endtask

    task automatic check_all(input string req);
        check(req, "div_ratio", 32'(div_ratio), 32'(e_div));
        check(req, "ref_code", 32'(ref_code), 32'(e_ref));
        check(req, "cp_code", 32'(cp_code), 32'(e_cp));
        check(req, "band_code", 32'(band_code), 32'(e_band));
        check(req, "if_sel", 32'(if_sel), 32'(e_if));
        check(req, "test_en", 32'(test_en), 32'(e_te));
        check(req, "port_drv", 32'(port_drv), 32'(f_ports(e_te, e_pb, fdiv_half, fcmp)));
        check(req, "cp_mode", 32'(cp_mode), 32'(f_cp(e_te, e_pb)));
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; hq();
        sda_m = 1'b0; hq();
        scl_m = 1'b0; hq();
    endtask

    task automatic i2c_stop();
        scl_m = 1'b0; sda_m = 1'b0; hq();
        scl_m = 1'b1; hq();
        sda_m = 1'b1; hq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7 - i]; hq();
            scl_m = 1'b1; hq();
            scl_m = 1'b0; hq();
        end
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; hq();
        scl_m = 1'b1; hq();
        ack = ~sda_line;
        scl_m = 1'b0; hq();
    endtask

    task automatic rbyte(output logic [7:0] d, input logic mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hq();
            scl_m = 1'b1; hq();
            d[i] = sda_line;
            scl_m = 1'b0;
        end
        hq();
        sda_m = ~mack; hq();
        scl_m = 1'b1; hq();
        scl_m = 1'b0; hq();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] a_byte(logic [1:0] ma, logic rw);
        return {5'b11000, ma, rw};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] bs[6], input int n, input string req);
        logic ack, hit;
        hit = (a[7:1] == {5'b11000, addr_sel}) && !a[0];
        i2c_start();
        wbyte(a, ack);
        check(hit ? "R7" : "R1", "address ack", 32'(ack), 32'(hit));
        e_ph = 2'd0;
        for (int i = 0; i < n; i++) begin
            wbyte(bs[i], ack);
            if (hit) begin
                m_byte(bs[i]);
                check("R7", "data ack", 32'(ack), 1);
            end else check("R1", "data ack on foreign address", 32'(ack), 0);
        end
        i2c_stop();
        if (hit) m_stop();
        hq();
        check_all(req);
    endtask

    task automatic rd(input int n, input string req);
        logic ack;
        logic [7:0] d;
        i2c_start();
        wbyte(a_byte(addr_sel, 1'b1), ack);
        check("R7", "read address ack", 32'(ack), 1);
        for (int j = 0; j < n; j++) begin
            rbyte(d, j < n - 1);
            check(req, "status byte", 32'(d),
                  32'({e_por, f_fl(e_te, e_pb, pll_lock), 3'b000, addr_sel, 1'b0}));
        end
        i2c_stop();
        e_por = 1'b0;
        hq();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] bs[6];
        logic [7:0] d;
        logic ack;
        void'($urandom(32'd6151));
        repeat (4) @(negedge clk);
        check("R7", "sda_pull in reset", 32'(sda_pull), 0);
        rst_n = 1'b1;
        hq();
        check_all("R11");

        // R10 / R8: POR readable after reset, cleared by the STOP of a read
        rd(2, "R8");
        rd(1, "R10");

        // R2: atomic ratio update
        i2c_start();
        wbyte(a_byte(addr_sel, 1'b0), ack);
        wbyte(8'h11, ack);
        check("R2", "ratio held after high byte", 32'(div_ratio), 32'(e_div));
        wbyte(8'h22, ack);
        check("R2", "ratio after low byte", 32'(div_ratio), 32'h1122);
        // R3: lone high byte, then STOP
        wbyte(8'h05, ack);
        i2c_stop(); hq();
        e_div = 15'h0522;
        check("R3", "ratio after stop", 32'(div_ratio), 32'h0522);

        // R4: control pair, codes kept as written
        bs = '{8'hE3, 8'hC5, 8'h0, 8'h0, 8'h0, 8'h0};
        wr(a_byte(addr_sel, 1'b0), bs, 2, "R4");
        bs = '{8'hA0, 8'h61, 8'h0, 8'h0, 8'h0, 8'h0};
        wr(a_byte(addr_sel, 1'b0), bs, 2, "R4");

        // R5: several pairs in one transfer
        bs = '{8'h7F, 8'h0F, 8'h9F, 8'h2A, 8'h12, 8'hF0};
        wr(a_byte(addr_sel, 1'b0), bs, 6, "R5");

        // R6: STOP inside a byte
        i2c_start();
        wbyte(a_byte(addr_sel, 1'b0), ack);
        wbyte(8'h81, ack);
        m_byte(8'h81);
        send_bits(8'hFF, 5);
        i2c_stop(); m_stop(); hq();
        check_all("R6");

        // R1: foreign prefix and foreign variable bits
        bs = '{8'h00, 8'h33, 8'hFF, 8'hFF, 8'h0, 8'h0};
        wr(8'hD4, bs, 4, "R1");
        wr(a_byte(~addr_sel, 1'b0), bs, 4, "R1");

        // R9: master NACK, slave stays silent
        e_por = 1'b0;
        i2c_start();
        wbyte(a_byte(addr_sel, 1'b1), ack);
        rbyte(d, 1'b0);
        rbyte(d, 1'b0);
        check("R9", "bus after nack", 32'(d), 32'hFF);
        check("R9", "sda_pull after nack", 32'(sda_pull), 0);
        i2c_stop(); hq();

        // R10: power event sets the flag again
        @(negedge clk) por_evt = 1'b1;
        @(negedge clk) por_evt = 1'b0;
        e_por = 1'b1;
        pll_lock = 1'b1;
        rd(1, "R10");
        rd(1, "R11");

        // R12: test selector table
        for (int t = 0; t < 8; t++) begin
            bs = '{8'h80, 8'(8'h10 | (t << 1)), 8'h0, 8'h0, 8'h0, 8'h0};
            wr(a_byte(addr_sel, 1'b0), bs, 2, "R12");
            for (int k = 0; k < 2; k++) begin
                fdiv_half = k[0]; fcmp = ~k[0]; pll_lock = k[0];
                hq();
                check("R12", "port_drv", 32'(port_drv), 32'(f_ports(e_te, e_pb, fdiv_half, fcmp)));
                check("R12", "cp_mode", 32'(cp_mode), 32'(f_cp(e_te, e_pb)));
            end
            rd(1, "R12");
        end
        bs = '{8'h80, 8'h0B, 8'h0, 8'h0, 8'h0, 8'h0};
        wr(a_byte(addr_sel, 1'b0), bs, 2, "R11");

        // random mix
        for (int k = 0; k < 30; k++) begin
            int kind = int'($urandom_range(0, 4));
            int n;
            pll_lock = 1'($urandom); fdiv_half = 1'($urandom); fcmp = 1'($urandom);
            for (int i = 0; i < 6; i++) bs[i] = 8'($urandom);
            case (kind)
                0: begin bs[0][7] = 1'b0; n = 2; end
                1: begin bs[0][7] = 1'b1; n = 2; end
                2: n = 4 + 2 * int'($urandom_range(0, 1));
                3: begin bs[0][7] = 1'b0; n = 1; end
                default: n = 0;
            endcase
            if (kind == 4) rd(1 + int'($urandom_range(0, 1)), "R8");
            else wr(a_byte(addr_sel, 1'b0), bs, n, kind == 3 ? "R3" : "R5");
        end
        finish_run();
    end
endmodule